// File: doc/BRIEF.md
# Timer Capture/Compare/PWM Channel

This block is a single channel of a general-purpose timer. It watches a free-running counter that is shared with other channels and that wraps back to zero after it reaches a programmable modulo value. The counter itself is not part of this block. A one-byte control/status register sets the channel up in one of three modes. In input-capture mode the counter value is latched when a chosen edge arrives on the pin. In output-compare mode the pin is changed when the counter equals the channel value. In edge-aligned PWM mode the pin is raised at each counter wrap and dropped when the programmed width has elapsed.

Any of these events sets a channel flag, and the flag can raise an interrupt request. Software clears the flag by writing a zero to its bit. A force-high bit holds the pin at 100 % duty, and a channel value of zero gives 0 % duty in PWM mode.

An even channel can run in buffered mode. In that mode it also owns the value register of its odd partner, and a newly written compare value takes effect only at the next counter wrap. This avoids a glitch in the middle of a period. The pin input goes through a two-flop synchronizer before edge detection.

Top module: `tcc_channel`

## Requirements
- R1: After reset, the control byte reads 0x00, both value registers read 0, and `pin_out`, `pin_oe` and `irq_req` are 0.
- R2: The control byte has this layout: bit 7 flag, bit 6 interrupt enable, bit 5 buffered select, bit 4 compare select, bits 3:2 action, bit 1 toggle-on-wrap, bit 0 force-high. Bits 6:0 read back as written. Writing 1 to bit 7 has no effect. When `HAS_PAIR` is 0, bit 5 cannot be set and reads 0.
- R3: Writing the control byte with bit 7 at 0 clears the flag one cycle later. If a capture or match event occurs in the same cycle as that write, the flag stays set.
- R4: Capture mode is selected when bits 5:4 are 00. Action 01 captures on a rising edge, 10 on a falling edge and 11 on either edge; 00 disables capture. On a qualifying edge of the synchronized pin, `tmr_count` is copied into the channel value and the flag is set in the same clock cycle.
- R5: Compare mode is selected when bit 4 or bit 5 is 1. A match is a cycle with `tmr_tick` high and `tmr_count` equal to the channel value. A match sets the flag and applies the action to the pin one cycle later: 01 toggles, 10 drives low, 11 drives high. Without `tmr_tick` there is no match.
- R6: In compare mode with bit 1 set (except the PWM combination), the pin toggles on each tick where `tmr_wrap` is high. A match in the same tick takes precedence over the toggle.
- R7: PWM is compare mode with action 10 and bit 1 set. After the tick in which the counter moves to value n, the pin is high exactly when n is below the channel value. So value 0 gives 0 % duty, and any value above the modulo gives 100 %.
- R8: In compare and PWM modes, force-high (bit 0) holds `pin_out` at 1.
- R9: In buffered mode, the compare/PWM value in use changes only on a wrap tick. At that tick it loads whichever value register, own or partner, was written most recently.
- R10: `irq_req` is high exactly while both the flag and the interrupt enable are set.
- R11: `pin_oe` is high only in compare/PWM mode with a nonzero action. In all other cases `pin_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_tick | input | 1 | Shared counter advances at the end of this cycle |
| tmr_count | input | CNT_W | Current value of the shared counter |
| tmr_wrap | input | 1 | Counter equals the modulo value (wraps on this tick) |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read data |
| val_wr | input | 1 | Write strobe for the channel value |
| val_wdata | input | CNT_W | Channel value write data |
| val_rdata | output | CNT_W | Channel value (captured or programmed) |
| pair_wr | input | 1 | Write strobe for the partner value register |
| pair_wdata | input | CNT_W | Partner value write data |
| pair_rdata | output | CNT_W | Partner value register |
| pin_in | input | 1 | Asynchronous capture pin |
| pin_out | output | 1 | Compare/PWM pin level |
| pin_oe | output | 1 | Channel drives the pin |
| irq_req | output | 1 | Interrupt request |

## Verification
On every cycle, assertions check these properties:
- a capture event is followed by a set flag;
- a clearing write with no competing event leaves the flag at zero;
- a drive-high match always raises the pin;
- a zero-width PWM wrap never raises the pin;
- the buffered value holds steady between wraps.

The bench scenarios cover what needs a full counter period or a sequence of writes. They sweep every action and toggle combination against every compare value over two periods. They sweep PWM widths from 0 to beyond the modulo. They check which edges each capture setting accepts. They check that buffered width changes only at period boundaries and follow the most recent register written.

// File: rtl/tcc_pkg.sv
// Shared types for the timer capture/compare/PWM channel.
// Assumes an 8-bit control byte whose bit layout is fixed by software.
package tcc_pkg;

    typedef struct packed {
        logic       flag;      // event flag, software clears by writing 0
        logic       irq_en;    // interrupt enable
        logic       buf_sel;   // buffered compare/PWM (even channel only)
        logic       cmp_sel;   // compare/PWM select
        logic [1:0] act;       // capture edge or compare pin action
        logic       ovf_tgl;   // toggle pin on counter wrap
        logic       force_hi;  // hold pin high (100 % duty)
    } tcc_ctl_t;

    localparam logic [1:0] ACT_NONE = 2'b00;
    localparam logic [1:0] ACT_TGL  = 2'b01;  // capture: rising edge
    localparam logic [1:0] ACT_LOW  = 2'b10;  // capture: falling edge
    localparam logic [1:0] ACT_HIGH = 2'b11;  // capture: either edge

endpackage

// File: rtl/tcc_edge_detect.sv
// Synchronizes an asynchronous pin and flags the selected edge kinds.
// Assumes STAGES >= 2; sel[0] enables rising, sel[1] falling edges.
module tcc_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_in,
    input  logic [1:0] sel,
    output logic       evt
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sync_r;
    logic              last_r;
    logic              rise;
    logic              fall;

    // Synchronizer chain; each stage samples the one before it.
    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_r[gi] <= 1'b0;
                    else        sync_r[gi] <= pin_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_r[gi] <= 1'b0;
                    else        sync_r[gi] <= sync_r[gi-1];
                end
            end
        end
    endgenerate

    // Previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) last_r <= 1'b0;
        else        last_r <= sync_r[TOP];
    end

    // Edge qualification against the selected kinds.
    always_comb begin
        rise = sync_r[TOP] & ~last_r;
        fall = ~sync_r[TOP] & last_r;
        evt  = (sel[0] & rise) | (sel[1] & fall);
    end
endmodule

// File: rtl/tcc_value_bank.sv
// Holds the channel value, the optional partner value and the value in
// use for compare/PWM. In buffered mode the value in use reloads only on
// a wrap tick from the register written most recently.
module tcc_value_bank #(
    parameter int CNT_W    = 16,
    parameter bit HAS_PAIR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prim_wr,
    input  logic [CNT_W-1:0] prim_wdata,
    input  logic             pair_wr,
    input  logic [CNT_W-1:0] pair_wdata,
    input  logic             cap_evt,
    input  logic [CNT_W-1:0] cap_value,
    input  logic             buffered,
    input  logic             wrap_tick,
    output logic [CNT_W-1:0] prim_q,
    output logic [CNT_W-1:0] pair_q,
    output logic [CNT_W-1:0] active,
    output logic [CNT_W-1:0] active_next
);
    logic [CNT_W-1:0] prim_r;
    logic [CNT_W-1:0] act_r;
    logic [CNT_W-1:0] candidate;
    logic             use_pair;

    // Own value register: capture has priority over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       prim_r <= '0;
        else if (cap_evt) prim_r <= cap_value;
        else if (prim_wr) prim_r <= prim_wdata;
    end

    generate
        if (HAS_PAIR) begin : g_pair
            logic [CNT_W-1:0] pair_r;
            logic             last_pair_r;

            // Partner value register.
            always_ff @(posedge clk) begin
                if (!rst_n)       pair_r <= '0;
                else if (pair_wr) pair_r <= pair_wdata;
            end

            // Remembers which register software touched last.
            always_ff @(posedge clk) begin
                if (!rst_n)                  last_pair_r <= 1'b0;
                else if (prim_wr || cap_evt) last_pair_r <= 1'b0;
                else if (pair_wr)            last_pair_r <= 1'b1;
            end

            assign pair_q   = pair_r;
            assign use_pair = last_pair_r;
        end else begin : g_solo
            assign pair_q   = '0;
            assign use_pair = 1'b0;
        end
    endgenerate

    // Value in use: tracks own register unbuffered, reloads at wrap buffered.
    always_ff @(posedge clk) begin
        if (!rst_n)         act_r <= '0;
        else if (!buffered) act_r <= prim_r;
        else if (wrap_tick) act_r <= candidate;
    end

    // Selection of the next and current value in use.
    always_comb begin
        candidate   = use_pair ? pair_q : prim_r;
        prim_q      = prim_r;
        active      = buffered ? act_r : prim_r;
        if (!buffered)      active_next = prim_r;
        else if (wrap_tick) active_next = candidate;
        else                active_next = act_r;
    end

    assert_buf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (buffered && !wrap_tick) |=> $stable(act_r));
endmodule

// File: rtl/tcc_pin_ctrl.sv
// Output side of the channel: compare match detection, compare pin actions,
// toggle on wrap, edge-aligned PWM and the force-high override.
// Assumes the counter value changes only on ticks.
module tcc_pin_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_mode,
    input  logic [1:0]       act,
    input  logic             ovf_tgl,
    input  logic             force_hi,
    input  logic             tmr_tick,
    input  logic             tmr_wrap,
    input  logic [CNT_W-1:0] tmr_count,
    input  logic [CNT_W-1:0] active,
    input  logic [CNT_W-1:0] active_next,
    output logic             match_evt,
    output logic             pin_out,
    output logic             pin_oe
);
    import tcc_pkg::*;

    localparam int EXT_W = CNT_W + 1;

    logic             drive;
    logic             pwm;
    logic             hit;
    logic             hit_early;
    logic             wrap_tick;
    logic [EXT_W-1:0] count_plus;
    logic             pin_q;
    logic             pin_d;

    // Mode decode and match detection.
    always_comb begin
        drive      = cmp_mode && (act != ACT_NONE);
        pwm        = drive && ovf_tgl && (act == ACT_LOW);
        wrap_tick  = tmr_tick && tmr_wrap;
        hit        = tmr_tick && (tmr_count == active);
        count_plus = {1'b0, tmr_count} + EXT_W'(1);
        hit_early  = tmr_tick && (count_plus == {1'b0, active});
        match_evt  = cmp_mode && hit;
    end

    // Next pin level from the configured action.
    always_comb begin
        pin_d = pin_q;
        if (!drive) begin
            pin_d = 1'b0;
        end else if (pwm) begin
            if (wrap_tick)      pin_d = (active_next != '0);
            else if (hit_early) pin_d = 1'b0;
        end else if (hit) begin
            case (act)
                ACT_TGL:  pin_d = ~pin_q;
                ACT_LOW:  pin_d = 1'b0;
                ACT_HIGH: pin_d = 1'b1;
                default:  pin_d = pin_q;
            endcase
        end else if (wrap_tick && ovf_tgl) begin
            pin_d = ~pin_q;
        end
    end

    // Pin level register.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    // Output with force-high override.
    always_comb begin
        pin_oe  = drive;
        pin_out = drive && (force_hi || pin_q);
    end

    assert_set_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && !pwm && hit && act == ACT_HIGH) |=> pin_q);

    assert_zero_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && wrap_tick && active_next == '0) |=> !pin_q);
endmodule

// File: rtl/tcc_channel.sv
// One timer channel: control byte with event flag, capture input path,
// value bank and compare/PWM output. The shared counter is external.
// Assumes tmr_wrap is high only while tmr_count equals the modulo value.
module tcc_channel #(
    parameter int CNT_W       = 16,
    parameter bit HAS_PAIR    = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_tick,
    input  logic [CNT_W-1:0] tmr_count,
    input  logic             tmr_wrap,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_wdata,
    output logic [7:0]       ctl_rdata,
    input  logic             val_wr,
    input  logic [CNT_W-1:0] val_wdata,
    output logic [CNT_W-1:0] val_rdata,
    input  logic             pair_wr,
    input  logic [CNT_W-1:0] pair_wdata,
    output logic [CNT_W-1:0] pair_rdata,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             irq_req
);
    import tcc_pkg::*;

    tcc_ctl_t         ctl_q;
    tcc_ctl_t         wr_ctl;
    logic             cap_mode;
    logic             cmp_mode;
    logic [1:0]       cap_sel;
    logic             cap_evt;
    logic             match_evt;
    logic             set_evt;
    logic             wrap_tick;
    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] active_next;

    // Mode decode and event collection.
    always_comb begin
        wr_ctl    = tcc_ctl_t'(ctl_wdata);
        cmp_mode  = ctl_q.cmp_sel || ctl_q.buf_sel;
        cap_mode  = !cmp_mode;
        cap_sel   = cap_mode ? ctl_q.act : ACT_NONE;
        wrap_tick = tmr_tick && tmr_wrap;
        set_evt   = cap_evt || match_evt;
    end

    // Control byte: configuration fields written directly, flag set by events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            if (ctl_wr) begin
                ctl_q.irq_en   <= wr_ctl.irq_en;
                ctl_q.buf_sel  <= HAS_PAIR ? wr_ctl.buf_sel : 1'b0;
                ctl_q.cmp_sel  <= wr_ctl.cmp_sel;
                ctl_q.act      <= wr_ctl.act;
                ctl_q.ovf_tgl  <= wr_ctl.ovf_tgl;
                ctl_q.force_hi <= wr_ctl.force_hi;
            end
            if (set_evt)                      ctl_q.flag <= 1'b1;
            else if (ctl_wr && !wr_ctl.flag)  ctl_q.flag <= 1'b0;
        end
    end

    tcc_edge_detect #(
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .sel    (cap_sel),
        .evt    (cap_evt)
    );

    tcc_value_bank #(
        .CNT_W    (CNT_W),
        .HAS_PAIR (HAS_PAIR)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .prim_wr     (val_wr),
        .prim_wdata  (val_wdata),
        .pair_wr     (pair_wr),
        .pair_wdata  (pair_wdata),
        .cap_evt     (cap_evt),
        .cap_value   (tmr_count),
        .buffered    (ctl_q.buf_sel),
        .wrap_tick   (wrap_tick),
        .prim_q      (val_rdata),
        .pair_q      (pair_rdata),
        .active      (active),
        .active_next (active_next)
    );

    tcc_pin_ctrl #(
        .CNT_W (CNT_W)
    ) u_pin (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_mode    (cmp_mode),
        .act         (ctl_q.act),
        .ovf_tgl     (ctl_q.ovf_tgl),
        .force_hi    (ctl_q.force_hi),
        .tmr_tick    (tmr_tick),
        .tmr_wrap    (tmr_wrap),
        .tmr_count   (tmr_count),
        .active      (active),
        .active_next (active_next),
        .match_evt   (match_evt),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe)
    );

    // Read data and interrupt request.
    always_comb begin
        ctl_rdata = ctl_q;
        irq_req   = ctl_q.flag && ctl_q.irq_en;
    end

    assert_capture_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> ctl_q.flag);

    assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_wdata[7] && !set_evt) |=> !ctl_q.flag);
endmodule

// File: tb/tcc_channel_bench.sv
`timescale 1ns/1ps
module tcc_channel_bench;
    localparam int W   = 16;
    localparam int MOD = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tmr_tick = 1'b0;
    logic [W-1:0] tmr_count = '0;
    logic         tmr_wrap = 1'b0;
    logic         ctl_wr = 1'b0;
    logic [7:0]   ctl_wdata = '0;
    logic [7:0]   ctl_rdata;
    logic         val_wr = 1'b0;
    logic [W-1:0] val_wdata = '0;
    logic [W-1:0] val_rdata;
    logic         pair_wr = 1'b0;
    logic [W-1:0] pair_wdata = '0;
    logic [W-1:0] pair_rdata;
    logic         pin_in = 1'b0;
    logic         pin_out;
    logic         pin_oe;
    logic         irq_req;

    logic         o_wr = 1'b0;
    logic [7:0]   o_wdata = '0;
    logic [7:0]   o_rdata;
    logic [W-1:0] o_val;
    logic [W-1:0] o_pair;
    logic         o_pin;
    logic         o_oe;
    logic         o_irq;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    tcc_channel #(.CNT_W(W), .HAS_PAIR(1'b1)) u_tcc_channel (
        .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .tmr_count(tmr_count),
        .tmr_wrap(tmr_wrap), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .val_wr(val_wr), .val_wdata(val_wdata),
        .val_rdata(val_rdata), .pair_wr(pair_wr), .pair_wdata(pair_wdata),
        .pair_rdata(pair_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_req(irq_req));

    tcc_channel #(.CNT_W(W), .HAS_PAIR(1'b0)) u_odd (
        .clk(clk), .rst_n(rst_n), .tmr_tick(1'b0), .tmr_count('0),
        .tmr_wrap(1'b0), .ctl_wr(o_wr), .ctl_wdata(o_wdata),
        .ctl_rdata(o_rdata), .val_wr(1'b0), .val_wdata('0),
        .val_rdata(o_val), .pair_wr(1'b0), .pair_wdata('0),
        .pair_rdata(o_pair), .pin_in(1'b0), .pin_out(o_pin),
        .pin_oe(o_oe), .irq_req(o_irq));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [7:0] d);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
        @(posedge clk); #1 ctl_wr = 1'b0;
    endtask

    task automatic write_val(input int d);
        @(negedge clk); val_wr = 1'b1; val_wdata = W'(d);
        @(posedge clk); #1 val_wr = 1'b0;
    endtask

    task automatic write_pair(input int d);
        @(negedge clk); pair_wr = 1'b1; pair_wdata = W'(d);
        @(posedge clk); #1 pair_wr = 1'b0;
    endtask

    // One counter tick at count c; outputs are sampled 1 ns after the edge.
    task automatic step(input int c);
        @(negedge clk);
        tmr_count = W'(c); tmr_wrap = (c == MOD); tmr_tick = 1'b1;
        @(posedge clk); #1 tmr_tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int cap_last;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: reset state
        chk(ctl_rdata == 8'h00, "R1 ctl", ctl_rdata, 0);
        chk(val_rdata == '0 && pair_rdata == '0, "R1 values", val_rdata, 0);
        chk(!pin_out && !pin_oe && !irq_req, "R1 outputs", {pin_out, pin_oe, irq_req}, 0);

        // R2: readback, flag write-1 ignored, odd channel bit 5
        write_ctl(8'hFF);
        chk(ctl_rdata == 8'h7F, "R2 readback", ctl_rdata, 8'h7F);
        write_ctl(8'h00);
        chk(ctl_rdata == 8'h00, "R2 readback zero", ctl_rdata, 0);
        @(negedge clk); o_wr = 1'b1; o_wdata = 8'hFF;
        @(posedge clk); #1 o_wr = 1'b0;
        chk(o_rdata == 8'h5F, "R2 odd bit5", o_rdata, 8'h5F);
        write_val(16'hA5C3);
        chk(val_rdata == 16'hA5C3, "R2 value readback", val_rdata, 16'hA5C3);

        // R4: capture edge selection for every action and edge kind
        cap_last = 16'hA5C3;
        for (int a = 0; a < 4; a++) begin
            for (int e = 0; e < 2; e++) begin
                bit rising;
                bit expect_cap;
                write_ctl(8'(a << 2));
                @(negedge clk);
                rising = !pin_in;
                tmr_count = W'(16'h1000 + a * 16 + e);
                pin_in = ~pin_in;
                repeat (5) @(posedge clk);
                #1;
                expect_cap = (a == 3) || (a == 1 && rising) || (a == 2 && !rising);
                if (expect_cap) cap_last = 16'h1000 + a * 16 + e;
                chk(ctl_rdata[7] == expect_cap, "R4 capture flag", ctl_rdata[7], expect_cap);
                chk(val_rdata == W'(cap_last), "R4 capture value", val_rdata, cap_last);
                write_ctl(8'(a << 2));
                chk(ctl_rdata[7] == 1'b0, "R3 flag cleared", ctl_rdata[7], 0);
            end
        end
        if (pin_in) begin
            write_ctl(8'h00);
            @(negedge clk); pin_in = 1'b0;
            repeat (4) @(posedge clk);
        end

        // R5/R6: compare action x wrap toggle x value, two periods each
        for (int a = 1; a < 4; a++) begin
            for (int t = 0; t < 2; t++) begin
                if (a == 2 && t == 1) continue;
                for (int v = 0; v <= MOD; v++) begin
                    bit model;
                    write_ctl(8'h00);
                    write_val(v);
                    write_ctl(8'(8'h10 | (a << 2) | (t << 1)));
                    model = 1'b0;
                    for (int p = 0; p < 2; p++) begin
                        for (int c = 0; c <= MOD; c++) begin
                            step(c);
                            if (c == v) begin
                                if (a == 1) model = ~model;
                                else if (a == 2) model = 1'b0;
                                else model = 1'b1;
                            end else if (c == MOD && t == 1) begin
                                model = ~model;
                            end
                            chk(pin_out == model && pin_oe,
                                (t == 1) ? "R6 toggle on wrap" : "R5 compare action",
                                pin_out, model);
                        end
                    end
                    chk(ctl_rdata[7] == 1'b1, "R5 match flag", ctl_rdata[7], 1);
                end
            end
        end

        // R5: no match without tick
        write_ctl(8'h00); write_val(3); write_ctl(8'h1C);
        @(negedge clk); tmr_count = 3; tmr_wrap = 1'b0;
        repeat (2) @(posedge clk); #1;
        chk(!pin_out && !ctl_rdata[7], "R5 no tick no match", {pin_out, ctl_rdata[7]}, 0);

        // R7: PWM width sweep including 0 % and above-modulo values
        for (int v = 0; v <= MOD + 2; v++) begin
            write_ctl(8'h00);
            write_val(v);
            write_ctl(8'h1A);
            step(MOD);
            for (int p = 0; p < 2; p++) begin
                for (int c = 0; c <= MOD; c++) begin
                    int n;
                    step(c);
                    n = (c == MOD) ? 0 : c + 1;
                    chk(pin_out == (n < v), "R7 pwm level", pin_out, (n < v));
                end
            end
        end

        // R8: force-high holds the pin in compare and in 0 % PWM
        write_ctl(8'h00); write_val(4); write_ctl(8'h19);
        for (int c = 0; c <= MOD; c++) begin
            step(c);
            chk(pin_out == 1'b1, "R8 force high compare", pin_out, 1);
        end
        write_ctl(8'h00); write_val(0); write_ctl(8'h1B);
        for (int c = 0; c <= MOD; c++) begin
            step(c);
            chk(pin_out == 1'b1, "R8 force high pwm", pin_out, 1);
        end

        // R9: buffered PWM widths change only at wraps, from latest register
        begin
            int widths [4] = '{3, 5, 2, 2};
            write_ctl(8'h00); write_val(3); write_ctl(8'h2A);
            step(MOD);
            for (int p = 0; p < 3; p++) begin
                for (int c = 0; c <= MOD; c++) begin
                    int n;
                    int w;
                    if (p == 0 && c == 2) write_pair(5);
                    if (p == 1 && c == 3) write_val(2);
                    step(c);
                    n = (c == MOD) ? 0 : c + 1;
                    w = (c == MOD) ? widths[p + 1] : widths[p];
                    chk(pin_out == (n < w), "R9 buffered width", pin_out, (n < w));
                end
            end
            chk(pair_rdata == 16'd5, "R9 pair readback", pair_rdata, 5);
        end

        // R10: interrupt request follows flag and enable
        write_ctl(8'h00); write_val(2); write_ctl(8'h54);
        step(2);
        chk(irq_req == 1'b1, "R10 irq set", irq_req, 1);
        write_ctl(8'h14);
        chk(irq_req == 1'b0 && ctl_rdata[7] == 1'b0, "R10 irq cleared", irq_req, 0);
        step(2);
        chk(irq_req == 1'b0 && ctl_rdata[7], "R10 irq disabled", irq_req, 0);

        // R3: set event wins over a same-cycle clearing write
        @(negedge clk);
        tmr_count = 2; tmr_wrap = 1'b0; tmr_tick = 1'b1;
        ctl_wr = 1'b1; ctl_wdata = 8'h14;
        @(posedge clk); #1 tmr_tick = 1'b0; ctl_wr = 1'b0;
        chk(ctl_rdata[7] == 1'b1, "R3 set wins", ctl_rdata[7], 1);

        // R11: no drive with action 00 or in capture mode
        write_ctl(8'h00); write_val(2); write_ctl(8'h12);
        for (int c = 0; c <= MOD; c++) begin
            step(c);
            chk(!pin_out && !pin_oe, "R11 action 00", {pin_out, pin_oe}, 0);
        end
        write_ctl(8'h0C);
        step(2);
        chk(!pin_out && !pin_oe, "R11 capture mode", {pin_out, pin_oe}, 0);

        finish_run();
    end
endmodule